// File: doc/BRIEF.md
# NAND Target Power-Up Initialization Sequencer

This host-side block takes a NAND target from power-up to a state where normal operations may run. It selects the target and waits for the ready/busy line to report ready. It then sends the reset command and waits for ready again. The target is assumed to be in the single-data-rate interface at timing mode 0 at that point, so every strobe runs at the slowest timing. The block then requests the parameter page, moves the read column to the start of the first copy, and clocks all 256 bytes in. Each byte is checked as it arrives. When the sequence ends, one of two sticky flags is set: a pass flag, after which the rest of the controller may issue reads, programs and erases, or a fail flag.

The block is a fixed script of bus steps. A step is a wait-for-ready, a command cycle, an address cycle, a page read or the final judgement. Every write and read strobe is low for a fixed number of clocks and then high for at least a fixed number of clocks. Both counts are parameters, and their defaults cover the slowest timing mode at a 250 MHz clock. A watchdog ends any wait in which the target stays busy too long.

Top module: `nand_init_seq`

## Requirements
- R1: While reset is asserted, the outputs are ce_n=1, we_n=1, re_n=1, cle=0, ale=0, dq_oe=0, init_done=0 and init_fail=0.
- R2: ce_n goes low after reset is released and stays low for the whole sequence and after init_done. No strobe goes low while ce_n is high.
- R3: Each wait step first idles GUARD_CYC clocks and then holds until the synchronized rb_n reads 1. No strobe falls while the target reports busy, and this includes the time before the first command.
- R4: The bus cycles, in order, are: command FFh, command ECh, address 00h, command 05h, address COL_ADDR[7:0], address COL_ADDR[15:8], command E0h. A command cycle has cle=1 and ale=0. An address cycle has ale=1 and cle=0. The value on dq_out when we_n rises is the cycle's byte. Wait steps come before FFh, after FFh, after the ECh address and after E0h.
- R5: Every we_n pulse is low for exactly LO_CYC clocks. Between pulses, we_n is high for at least HI_CYC clocks. During each pulse cle, ale and dq_out are already stable one clock before the fall, and dq_oe is 1.
- R6: After the last wait, exactly 256 re_n pulses occur. Each is low for exactly LO_CYC clocks and high for at least HI_CYC clocks between pulses, with dq_oe=0. dq_in is captured on the last low clock of each pulse.
- R7: The page is valid when both of the following hold. First, bytes 0..3 are 4Fh, 4Eh, 46h and 49h. Second, a CRC-16 over bytes 0..253 equals byte 254 | (byte 255 << 8). The CRC uses polynomial 8005h, seed 4F4Eh, processes each byte MSB first and applies no reflection. A valid page sets init_done, which stays at 1 with ce_n kept low.
- R8: A page with a wrong signature or a wrong CRC sets init_fail. init_fail stays set, ce_n goes high, and no further strobe falls.
- R9: If rb_n stays low for BUSY_LIMIT consecutive clocks in any wait, init_fail is set and no further strobe falls. Shorter busy periods do not cause a failure.
- R10: cle and ale are never both high, and we_n and re_n are never both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rb_n | input | 1 | Target ready/busy, low while busy |
| dq_in | input | 8 | Data bus from the target |
| ce_n | output | 1 | Chip enable, active low |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| we_n | output | 1 | Write strobe, active low |
| re_n | output | 1 | Read strobe, active low |
| dq_out | output | 8 | Data bus to the target |
| dq_oe | output | 1 | Output enable for dq_out |
| init_done | output | 1 | Sticky: page valid, target usable |
| init_fail | output | 1 | Sticky: invalid page or busy timeout |

## Verification
The bench builds the block with LO_CYC=2, HI_CYC=1, GUARD_CYC=3, BUSY_LIMIT=40 and COL_ADDR=0. These short strobes and guards let six full runs, each with a 256-byte page, finish in a few thousand clocks. The target model stays busy for 20 to 25 clocks after power-up, after reset and after the page request. This is below the watchdog limit, so legitimate busy periods are exercised without tripping it. A target that never becomes ready, either from power-up or after the reset command, reaches the watchdog within a few dozen clocks, so its timing can be checked against a narrow window.

// File: rtl/nand_init_pkg.sv
package nand_init_pkg;

  localparam int unsigned PAGE_LEN = 256;
  localparam int unsigned CRC_LEN  = PAGE_LEN - 2;
  localparam logic [15:0] CRC_SEED = 16'h4F4E;
  localparam logic [15:0] CRC_POLY = 16'h8005;
  // signature bytes, byte 0 in the low lane
  localparam logic [31:0] SIG_WORD = 32'h49464E4F;

  typedef enum logic [2:0] {
    K_WAIT, K_CMD, K_ADDR, K_READ, K_JUDGE
  } step_kind_e;

  typedef struct packed {
    step_kind_e  kind;
    logic [7:0]  val;
  } step_t;

  function automatic step_t script_step(input logic [3:0] idx, input logic [15:0] col);
    step_t s;
    s.kind = K_JUDGE;
    s.val  = 8'h00;
    case (idx)
      4'd0:  s.kind = K_WAIT;
      4'd1:  begin s.kind = K_CMD;  s.val = 8'hFF; end
      4'd2:  s.kind = K_WAIT;
      4'd3:  begin s.kind = K_CMD;  s.val = 8'hEC; end
      4'd4:  begin s.kind = K_ADDR; s.val = 8'h00; end
      4'd5:  s.kind = K_WAIT;
      4'd6:  begin s.kind = K_CMD;  s.val = 8'h05; end
      4'd7:  begin s.kind = K_ADDR; s.val = col[7:0]; end
      4'd8:  begin s.kind = K_ADDR; s.val = col[15:8]; end
      4'd9:  begin s.kind = K_CMD;  s.val = 8'hE0; end
      4'd10: s.kind = K_WAIT;
      4'd11: s.kind = K_READ;
      default: s.kind = K_JUDGE;
    endcase
    return s;
  endfunction

  function automatic logic [15:0] crc16_byte(input logic [15:0] crc, input logic [7:0] b);
    logic [15:0] c;
    c = crc ^ {b, 8'h00};
    for (int i = 0; i < 8; i++) begin
      c = c[15] ? ((c << 1) ^ CRC_POLY) : (c << 1);
    end
    return c;
  endfunction

endpackage

// File: rtl/nand_rb_sync.sv
module nand_rb_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rb_n,
  output logic ready
);
  generate
    if (STAGES <= 1) begin : g_single
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= 1'b0;
        else        q <= rb_n;
      end
      assign ready = q;
    end else begin : g_chain
      logic [STAGES-1:0] sh;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-2:0], rb_n};
      end
      assign ready = sh[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/nand_strobe_gen.sv
module nand_strobe_gen #(
  parameter int unsigned LO_CYC = 13,
  parameter int unsigned HI_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic strobe_n,
  output logic sample,
  output logic done
);
  localparam int unsigned MAXC = (LO_CYC > HI_CYC) ? LO_CYC : HI_CYC;
  localparam int unsigned CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] LO_LAST = CW'(LO_CYC - 1);
  localparam logic [CW-1:0] HI_LAST = CW'(HI_CYC - 1);

  typedef enum logic [1:0] {SG_IDLE, SG_LO, SG_HI} sg_e;

  sg_e           st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          strobe_q;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    case (st_q)
      SG_IDLE: if (start) begin st_d = SG_LO; cnt_d = LO_LAST; end
      SG_LO: begin
        if (cnt_q == '0) begin st_d = SG_HI; cnt_d = HI_LAST; end
        else cnt_d = cnt_q - 1'b1;
      end
      SG_HI: begin
        if (cnt_q == '0) st_d = SG_IDLE;
        else cnt_d = cnt_q - 1'b1;
      end
      default: st_d = SG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= SG_IDLE;
      cnt_q    <= '0;
      strobe_q <= 1'b1;
    end else begin
      st_q     <= st_d;
      cnt_q    <= cnt_d;
      strobe_q <= (st_d != SG_LO);
    end
  end

  assign strobe_n = strobe_q;
  assign sample   = (st_q == SG_LO) && (cnt_q == '0);
  assign done     = (st_q == SG_HI) && (cnt_q == '0);

  // R5/R6: a new pulse is only requested when the previous one is over
  a_r5_start_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> st_q == SG_IDLE);
  // R5/R6: the pin is low exactly while the low phase runs
  a_r6_pin_tracks_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SG_LO) |-> !strobe_n);
  a_r5_rise_after_sample: assert property (@(posedge clk) disable iff (!rst_n)
    sample |=> strobe_n);
endmodule

// File: rtl/nand_page_check.sv
module nand_page_check
  import nand_init_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       byte_vld,
  input  logic [7:0] byte_in,
  input  logic [7:0] idx,
  output logic       page_ok
);
  logic [15:0] crc_q, stored_q;
  logic        sig_ok_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q    <= CRC_SEED;
      stored_q <= '0;
      sig_ok_q <= 1'b0;
    end else if (clr) begin
      crc_q    <= CRC_SEED;
      stored_q <= '0;
      sig_ok_q <= 1'b1;
    end else if (byte_vld) begin
      if (idx < 8'd4 && byte_in != SIG_WORD[idx[1:0]*8 +: 8])
        sig_ok_q <= 1'b0;
      if (32'(idx) < CRC_LEN)
        crc_q <= crc16_byte(crc_q, byte_in);
      if (32'(idx) == CRC_LEN)
        stored_q[7:0] <= byte_in;
      if (32'(idx) == CRC_LEN + 1)
        stored_q[15:8] <= byte_in;
    end
  end

  assign page_ok = sig_ok_q && (crc_q == stored_q);

  // R7: a signature mismatch is never forgotten until a new fetch starts
  a_r7_sig_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!sig_ok_q && !clr) |=> !sig_ok_q);
endmodule

// File: rtl/nand_init_seq.sv
module nand_init_seq
  import nand_init_pkg::*;
#(
  parameter int unsigned LO_CYC      = 13,
  parameter int unsigned HI_CYC      = 8,
  parameter int unsigned GUARD_CYC   = 50,
  parameter int unsigned BUSY_LIMIT  = 250000,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [15:0] COL_ADDR    = 16'h0000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rb_n,
  input  logic [7:0] dq_in,
  output logic       ce_n,
  output logic       cle,
  output logic       ale,
  output logic       we_n,
  output logic       re_n,
  output logic [7:0] dq_out,
  output logic       dq_oe,
  output logic       init_done,
  output logic       init_fail
);
  localparam int unsigned GW = $clog2(GUARD_CYC + 1);
  localparam int unsigned WW = $clog2(BUSY_LIMIT + 1);
  localparam logic [GW-1:0] G_LAST  = GW'(GUARD_CYC - 1);
  localparam logic [WW-1:0] WD_LAST = WW'(BUSY_LIMIT - 1);
  localparam logic [7:0]    B_LAST  = 8'(PAGE_LEN - 1);

  typedef enum logic [3:0] {
    ST_FETCH, ST_SETUP, ST_WBUS, ST_GUARD, ST_WAIT,
    ST_RGO, ST_RBUS, ST_DONE, ST_FAIL
  } st_e;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i = rsync_q[1];

  st_e           st_q, st_d;
  logic [3:0]    step_q, step_d;
  logic [7:0]    byte_q, byte_d;
  logic [GW-1:0] g_q, g_d;
  logic [WW-1:0] wd_q, wd_d;
  logic          cle_q, cle_d, ale_q, ale_d, oe_q, oe_d, ce_q;
  logic [7:0]    dq_q, dq_d;
  logic          we_start, re_start, chk_clr;
  logic          we_done, re_done, re_sample, we_smp_unused;
  logic          rdy, page_ok;
  step_t         cur;

  nand_rb_sync #(.STAGES(SYNC_STAGES)) u_rb (
    .clk(clk), .rst_n(rst_i), .rb_n(rb_n), .ready(rdy));

  nand_strobe_gen #(.LO_CYC(LO_CYC), .HI_CYC(HI_CYC)) u_we (
    .clk(clk), .rst_n(rst_i), .start(we_start),
    .strobe_n(we_n), .sample(we_smp_unused), .done(we_done));

  nand_strobe_gen #(.LO_CYC(LO_CYC), .HI_CYC(HI_CYC)) u_re (
    .clk(clk), .rst_n(rst_i), .start(re_start),
    .strobe_n(re_n), .sample(re_sample), .done(re_done));

  nand_page_check u_chk (
    .clk(clk), .rst_n(rst_i), .clr(chk_clr), .byte_vld(re_sample),
    .byte_in(dq_in), .idx(byte_q), .page_ok(page_ok));

  assign cur = script_step(step_q, COL_ADDR);

  always_comb begin
    st_d     = st_q;
    step_d   = step_q;
    byte_d   = byte_q;
    g_d      = g_q;
    wd_d     = wd_q;
    cle_d    = cle_q;
    ale_d    = ale_q;
    oe_d     = oe_q;
    dq_d     = dq_q;
    we_start = 1'b0;
    re_start = 1'b0;
    chk_clr  = 1'b0;
    case (st_q)
      ST_FETCH: begin
        case (cur.kind)
          K_WAIT:  begin g_d = '0; wd_d = '0; st_d = ST_GUARD; end
          K_CMD:   begin cle_d = 1'b1; oe_d = 1'b1; dq_d = cur.val; st_d = ST_SETUP; end
          K_ADDR:  begin ale_d = 1'b1; oe_d = 1'b1; dq_d = cur.val; st_d = ST_SETUP; end
          K_READ:  begin byte_d = '0; chk_clr = 1'b1; st_d = ST_RGO; end
          default: st_d = page_ok ? ST_DONE : ST_FAIL;
        endcase
      end
      ST_SETUP: begin we_start = 1'b1; st_d = ST_WBUS; end
      ST_WBUS: begin
        if (we_done) begin
          cle_d  = 1'b0;
          ale_d  = 1'b0;
          oe_d   = 1'b0;
          step_d = step_q + 1'b1;
          st_d   = ST_FETCH;
        end
      end
      ST_GUARD: begin
        g_d = g_q + 1'b1;
        if (g_q == G_LAST) st_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (rdy) begin
          step_d = step_q + 1'b1;
          st_d   = ST_FETCH;
        end else if (wd_q == WD_LAST) begin
          st_d = ST_FAIL;
        end else begin
          wd_d = wd_q + 1'b1;
        end
      end
      ST_RGO: begin re_start = 1'b1; st_d = ST_RBUS; end
      ST_RBUS: begin
        if (re_done) begin
          if (byte_q == B_LAST) begin
            step_d = step_q + 1'b1;
            st_d   = ST_FETCH;
          end else begin
            byte_d = byte_q + 1'b1;
            st_d   = ST_RGO;
          end
        end
      end
      default: st_d = st_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      st_q   <= ST_FETCH;
      step_q <= '0;
      byte_q <= '0;
      g_q    <= '0;
      wd_q   <= '0;
      cle_q  <= 1'b0;
      ale_q  <= 1'b0;
      oe_q   <= 1'b0;
      dq_q   <= '0;
      ce_q   <= 1'b1;
    end else begin
      st_q   <= st_d;
      step_q <= step_d;
      byte_q <= byte_d;
      g_q    <= g_d;
      wd_q   <= wd_d;
      cle_q  <= cle_d;
      ale_q  <= ale_d;
      oe_q   <= oe_d;
      dq_q   <= dq_d;
      ce_q   <= (st_d == ST_FAIL);
    end
  end

  assign ce_n      = ce_q;
  assign cle       = cle_q;
  assign ale       = ale_q;
  assign dq_out    = dq_q;
  assign dq_oe     = oe_q;
  assign init_done = (st_q == ST_DONE);
  assign init_fail = (st_q == ST_FAIL);

  a_r10_latch_excl: assert property (@(posedge clk) disable iff (!rst_i)
    !(cle && ale));
  a_r10_strobe_excl: assert property (@(posedge clk) disable iff (!rst_i)
    !(!we_n && !re_n));
  a_r2_selected_in_pulse: assert property (@(posedge clk) disable iff (!rst_i)
    (!we_n || !re_n) |-> !ce_n);
  a_r5_setup_stable: assert property (@(posedge clk) disable iff (!rst_i)
    $fell(we_n) |-> ($stable(cle) && $stable(ale) && $stable(dq_out) && dq_oe));
  a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rst_i)
    init_done |=> init_done);
  a_r8_fail_releases: assert property (@(posedge clk) disable iff (!rst_i)
    init_fail |-> (ce_n && we_n && re_n && !init_done));
  a_r9_watchdog_bound: assert property (@(posedge clk) disable iff (!rst_i)
    32'(wd_q) < BUSY_LIMIT);
endmodule

// File: tb/nand_init_seq_test.sv
module nand_init_seq_test;
  localparam int LO = 2;
  localparam int HI = 1;
  localparam int GUARD = 3;
  localparam int LIMIT = 40;
  localparam int BUSY_T = 20;
  localparam logic [15:0] COL = 16'h0000;

  logic clk, rst_n;
  logic rb_n;
  logic [7:0] dq_in;
  logic ce_n, cle, ale, we_n, re_n, dq_oe, init_done, init_fail;
  logic [7:0] dq_out;

  nand_init_seq #(.LO_CYC(LO), .HI_CYC(HI), .GUARD_CYC(GUARD),
                  .BUSY_LIMIT(LIMIT), .SYNC_STAGES(2), .COL_ADDR(COL)) uut (
    .clk(clk), .rst_n(rst_n), .rb_n(rb_n), .dq_in(dq_in),
    .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n), .re_n(re_n),
    .dq_out(dq_out), .dq_oe(dq_oe), .init_done(init_done), .init_fail(init_fail));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // stimulus settings, written only by the main flow
  int         mode;        // 0 normal, 1 never ready, 2 stuck after reset command
  int         power_busy;
  logic [7:0] page [256];

  // target model and observer state, written only by the observer
  int         busy_cnt;
  bit         stuck_now;
  int         ptr, col_n;
  logic [15:0] col;
  logic [7:0] last_cmd;
  logic [9:0] got_q[$];
  int         we_falls, re_falls, re_rises;
  int         lo_w, hi_w, lo_r, hi_r;
  bit         seen_w, seen_r;
  logic       prev_we, prev_re, p_cle, p_ale;
  logic [7:0] p_dq;
  int         obs_checks, obs_fails;

  int tb_checks, tb_fails;

  assign rb_n  = !(busy_cnt != 0 || stuck_now);
  assign dq_in = page[ptr[7:0]];

  always @(negedge clk) begin
    if (!rst_n) begin
      busy_cnt = power_busy;
      stuck_now = (mode == 1);
      ptr = 0; col_n = 0; col = 16'h0; last_cmd = 8'h00;
      got_q.delete();
      we_falls = 0; re_falls = 0; re_rises = 0;
      lo_w = 0; hi_w = 0; lo_r = 0; hi_r = 0;
      seen_w = 0; seen_r = 0;
    end else begin
      if (busy_cnt > 0) busy_cnt = busy_cnt - 1;
      // write strobe
      if (prev_we && !we_n) begin
        we_falls++;
        obs_checks++;
        if (busy_cnt != 0 || stuck_now || ce_n || !dq_oe) begin
          obs_fails++;
          $display("FAIL R3/R2: strobe fall while busy/deselected actual=%0d/%0b expected=0/0", busy_cnt, ce_n);
        end
        obs_checks++;
        if (cle !== p_cle || ale !== p_ale || dq_out !== p_dq) begin
          obs_fails++;
          $display("FAIL R5: bus not set up before we_n fall actual=%0h expected=%0h", dq_out, p_dq);
        end
        if (seen_w) begin
          obs_checks++;
          if (hi_w < HI) begin
            obs_fails++;
            $display("FAIL R5: we_n high time actual=%0d expected>=%0d", hi_w, HI);
          end
        end
        lo_w = 1;
      end else if (!we_n) lo_w++;
      if (!prev_we && we_n) begin
        seen_w = 1; hi_w = 1;
        obs_checks++;
        if (lo_w != LO) begin
          obs_fails++;
          $display("FAIL R5: we_n low time actual=%0d expected=%0d", lo_w, LO);
        end
        got_q.push_back({cle, ale, dq_out});
        if (cle) begin
          last_cmd = dq_out;
          if (dq_out == 8'hFF) begin
            if (mode == 2) stuck_now = 1; else busy_cnt = BUSY_T;
          end
          if (dq_out == 8'h05) col_n = 0;
          if (dq_out == 8'hE0) ptr = int'(col);
        end
        if (ale) begin
          if (last_cmd == 8'h05) begin
            if (col_n == 0) col[7:0] = dq_out; else col[15:8] = dq_out;
            col_n++;
          end else if (last_cmd == 8'hEC) begin
            busy_cnt = BUSY_T; ptr = 0;
          end
        end
      end else if (we_n) hi_w++;
      // read strobe
      if (prev_re && !re_n) begin
        re_falls++;
        obs_checks++;
        if (dq_oe || ce_n || busy_cnt != 0 || stuck_now) begin
          obs_fails++;
          $display("FAIL R6: read pulse with bus driven/busy actual=%0b expected=0", dq_oe);
        end
        if (seen_r) begin
          obs_checks++;
          if (hi_r < HI) begin
            obs_fails++;
            $display("FAIL R6: re_n high time actual=%0d expected>=%0d", hi_r, HI);
          end
        end
        lo_r = 1;
      end else if (!re_n) lo_r++;
      if (!prev_re && re_n) begin
        seen_r = 1; hi_r = 1; re_rises++;
        obs_checks++;
        if (lo_r != LO) begin
          obs_fails++;
          $display("FAIL R6: re_n low time actual=%0d expected=%0d", lo_r, LO);
        end
        ptr = ptr + 1;
      end else if (re_n) hi_r++;
      obs_checks++;
      if ((cle && ale) || (!we_n && !re_n)) begin
        obs_fails++;
        $display("FAIL R10: exclusive lines actual=%0b%0b%0b%0b expected=no overlap", cle, ale, we_n, re_n);
      end
    end
    prev_we = we_n; prev_re = re_n; p_cle = cle; p_ale = ale; p_dq = dq_out;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tb_checks++;
    if (!ok) begin
      tb_fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_crc();
    logic [15:0] c;
    c = 16'h4F4E;
    for (int i = 0; i < 254; i++) begin
      c = c ^ {page[i], 8'h00};
      for (int k = 0; k < 8; k++) c = c[15] ? ((c << 1) ^ 16'h8005) : (c << 1);
    end
    return c;
  endfunction

  task automatic build_page(input int seed, input bit bad_sig, input bit bad_crc);
    logic [15:0] c;
    for (int i = 0; i < 256; i++) page[i] = 8'((i * seed + 17) ^ (i >> 3));
    page[0] = 8'h4F; page[1] = 8'h4E; page[2] = 8'h46; page[3] = 8'h49;
    if (bad_sig) page[2] = 8'h58;
    c = ref_crc();
    page[254] = c[7:0];
    page[255] = c[15:8];
    if (bad_crc) page[255] = page[255] ^ 8'h01;
  endtask

  task automatic run_case(input int m, input int seed, input bit bad_sig, input bit bad_crc);
    int cyc;
    int wf;
    logic [9:0] exp_rec [7];
    bit exp_ok;
    exp_rec[0] = {2'b10, 8'hFF}; exp_rec[1] = {2'b10, 8'hEC};
    exp_rec[2] = {2'b01, 8'h00}; exp_rec[3] = {2'b10, 8'h05};
    exp_rec[4] = {2'b01, COL[7:0]}; exp_rec[5] = {2'b01, COL[15:8]};
    exp_rec[6] = {2'b10, 8'hE0};
    exp_ok = (m == 0) && !bad_sig && !bad_crc;
    @(negedge clk); #1;
    rst_n = 1'b0; mode = m; power_busy = 25;
    build_page(seed, bad_sig, bad_crc);
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk(ce_n && we_n && re_n && !cle && !ale && !dq_oe && !init_done && !init_fail, "R1",
        {ce_n, we_n, re_n, cle, ale, dq_oe, init_done, init_fail}, 8'b11100000);
    rst_n = 1'b1;
    cyc = 0;
    while (!(init_done || init_fail) && cyc < 20000) begin
      @(negedge clk); cyc++;
    end
    #1;
    if (m == 0) begin
      chk(got_q.size() == 7, "R4 cycle count", got_q.size(), 7);
      for (int i = 0; i < 7; i++)
        if (i < got_q.size()) chk(got_q[i] == exp_rec[i], "R4 cycle value", got_q[i], exp_rec[i]);
      chk(re_rises == 256, "R6 read count", re_rises, 256);
      chk(init_done == exp_ok, "R7 done", init_done, exp_ok);
      chk(init_fail == !exp_ok, "R8 fail", init_fail, !exp_ok);
      chk(ce_n == !exp_ok, "R2/R8 ce_n", ce_n, !exp_ok);
    end else begin
      chk(init_fail && !init_done, "R9 fail", {init_done, init_fail}, 2'b01);
      chk(re_falls == 0, "R9 no reads", re_falls, 0);
      if (m == 1) begin
        chk(we_falls == 0, "R3 no strobe before ready", we_falls, 0);
        chk(cyc >= LIMIT && cyc <= LIMIT + GUARD + 8, "R9 watchdog time", cyc, LIMIT);
      end else begin
        chk(got_q.size() == 1, "R9 only reset sent", got_q.size(), 1);
      end
    end
    wf = we_falls + re_falls;
    repeat (30) @(negedge clk);
    #1;
    if (exp_ok) begin
      chk(init_done && !ce_n, "R7 done sticky", {init_done, ce_n}, 2'b10);
    end else begin
      chk(init_fail && ce_n, "R8 fail sticky", {init_fail, ce_n}, 2'b11);
      chk(we_falls + re_falls == wf, "R8 quiet after fail", we_falls + re_falls, wf);
    end
  endtask

  initial begin
    #(200000 * 4);
    $display("FAIL watchdog: run did not finish actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", tb_checks + obs_checks + 1, tb_fails + obs_fails + 1);
    $finish;
  end

  initial begin
    tb_checks = 0; tb_fails = 0; obs_checks = 0; obs_fails = 0;
    rst_n = 1'b0; mode = 0; power_busy = 25;
    build_page(3, 0, 0);
    run_case(0, 3, 0, 0);   // R7 valid page
    run_case(0, 11, 0, 0);  // R7 valid page, other content
    run_case(0, 5, 1, 0);   // R8 bad signature
    run_case(0, 7, 0, 1);   // R8 bad CRC
    run_case(1, 3, 0, 0);   // R9 never ready after power-up
    run_case(2, 3, 0, 0);   // R9 busy forever after reset command
    $display("[TB] %0d tests run, %0d failed", tb_checks + obs_checks, tb_fails + obs_fails);
    $finish;
  end
endmodule